// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Break Handling

This block recovers asynchronous serial characters from a single line that is sampled once per pulse of a sixteen-times-per-bit sample enable. A low sample in idle starts a candidate frame. The start bit is confirmed near its middle. The receiver then takes 5 to 8 data bits, least significant first, an optional parity bit and one stop bit. Each finished character is presented for one clock cycle, together with its data and three flags: parity error, framing error and break.

A line held low for a whole frame produces a single all-zero break character. After that the receiver ignores the line until it has seen two high samples in a row. A stop bit that is sampled low, when the rest of the frame is not all zero, is reported as a framing error, and that low sample is taken as the first sample of a new start bit.

States: `ST_IDLE` (waiting for a low sample), `ST_START` (confirming the start bit), `ST_DATA` (collecting data bits), `ST_PARITY` (taking the parity bit), `ST_STOP` (judging the stop bit), `ST_BRKCHK` (waiting out the rest of the stop bit on an all-low frame), `ST_MARK` (waiting for the line to recover after a break). Transitions:
- IDLE→START on a low sample.
- START→DATA when the start bit is confirmed low; START→IDLE when it is high at that point.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP.
- STOP→IDLE on a high stop sample.
- STOP→START (resynchronisation) on a low stop sample in a frame that is not all low.
- STOP→BRKCHK on a low stop sample in an all-low frame.
- BRKCHK→MARK when the line is still low; BRKCHK→IDLE when it has gone high.
- MARK→IDLE after two consecutive high samples.

Top module: `srx_receiver`

## Requirements
- R1: After reset `char_valid`, `char_data`, `char_perr`, `char_ferr` and `char_brk` are all 0 and the receiver is idle.
- R2: A start bit begins at the first low sample in idle (sample 1) and is confirmed at sample 8. If the line is high at sample 8, no character results. Seven low samples followed by high give nothing, and eight low samples start a frame.
- R3: Data bits are sampled 16 samples apart, the first one 16 samples after the start confirmation, least significant bit first. `cfg_wlen` codes 0,1,2,3 select 5,6,7,8 bits. Unused upper bits of `char_data` read 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=1 selects odd parity and 0 selects even parity. `char_perr` is 1 when the parity does not match. With `cfg_par_en`=0 no parity bit is taken and `char_perr` is 0.
- R5: `char_ferr` is 1 when the stop-bit sample is low.
- R6: When the line is low for every one of 16×(1+bits+parity+1) consecutive samples from the start sample, exactly one character is emitted, with data 0, `char_brk`=1, `char_ferr`=1 and `char_perr`=0.
- R7: After a break the receiver ignores low samples until two consecutive high samples have been seen. Only the next low sample after that begins a start bit.
- R8: After a framing error in a frame that is not all low, the low stop sample counts as sample 1 of a new start bit. That start bit is confirmed 7 samples later and the following character is received normally.
- R9: `char_valid` rises in the cycle that follows the clock edge of the deciding sample pulse and lasts one cycle. The state does not change on cycles without a sample pulse.
- R10: An all-low frame whose line is high at sample 16×frame bits gives one character with data 0, `char_ferr`=1 and `char_brk`=0, and the receiver returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Sample enable, 16 per bit time |
| cfg_wlen | input | 2 | Data length code: 0..3 gives 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| char_valid | output | 1 | One-cycle strobe for a finished character |
| char_data | output | 8 | Received data, right aligned |
| char_perr | output | 1 | Parity mismatch |
| char_ferr | output | 1 | Stop bit sampled low |
| char_brk | output | 1 | Break character |

## Verification
The assertions assume that the configuration inputs stay unchanged from the start of a frame until its character has been reported. The upper-bit check reads the live `cfg_wlen` in the cycle of the strobe. The stimulus therefore changes the configuration only between frames, while the line idles high. The line is changed only while `os_tick` is low, so every sample pulse sees a settled value. Random frames mix in wrong parity and stop bits that are low only at the sample point. Directed runs cover the start-confirmation boundary, the break threshold, one sample below it, the recovery interval and resynchronisation.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BRKCHK,
        ST_MARK
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
    } rx_cfg_t;

endpackage

// File: rtl/srx_subtimer.sv
module srx_subtimer #(
    parameter int OSR   = 16,
    parameter int SUB_W = $clog2(OSR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [SUB_W-1:0] target,
    output logic             hit
);

    logic [SUB_W-1:0] cnt_q;

    assign hit = tick && (cnt_q == target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end

    // R9: a restart always leaves the sub-sample count at zero
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R9: without a sample pulse or restart the count holds
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/srx_bitstore.sv
module srx_bitstore #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clear) begin
            word <= '0;
        end else if (wr) begin
            word[idx] <= bit_in;
        end
    end

    // R3: a cleared store starts every frame from zero
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word == '0));

endmodule

// File: rtl/srx_parity_chk.sv
module srx_parity_chk #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] word,
    input  logic              pbit,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              perr
);

    logic ones_odd;

    always_comb begin
        ones_odd = (^word) ^ pbit;
        perr     = par_en && (ones_odd != par_odd);
    end

endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MIN_W  = 5,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    output logic              char_valid,
    output logic [DATA_W-1:0] char_data,
    output logic              char_perr,
    output logic              char_ferr,
    output logic              char_brk
);

    localparam int SUB_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [SUB_W-1:0] START_T = SUB_W'(OSR / 2 - 2);
    localparam logic [SUB_W-1:0] BRK_T   = SUB_W'(OSR / 2 - 1);
    localparam logic [SUB_W-1:0] BIT_T   = SUB_W'(OSR - 1);

    rx_state_e state_q, state_d;
    rx_cfg_t   cfg_q;

    logic [IDX_W-1:0]  idx_q, idx_d, last_idx;
    logic              pbit_q, pbit_d;
    logic              mark_q, mark_d;
    logic              cfg_load;

    logic              tmr_hit, tmr_restart;
    logic [SUB_W-1:0]  tmr_target;
    logic              st_clear, st_wr;
    logic [DATA_W-1:0] word_q;
    logic              perr_w;

    logic              emit, emit_fe, emit_brk, emit_pe;

    srx_subtimer #(.OSR(OSR), .SUB_W(SUB_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .restart (tmr_restart),
        .target  (tmr_target),
        .hit     (tmr_hit)
    );

    srx_bitstore #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (st_clear),
        .wr     (st_wr),
        .idx    (idx_q),
        .bit_in (rx_line),
        .word   (word_q)
    );

    srx_parity_chk #(.DATA_W(DATA_W)) u_par (
        .word    (word_q),
        .pbit    (pbit_q),
        .par_en  (cfg_q.par_en),
        .par_odd (cfg_q.par_odd),
        .perr    (perr_w)
    );

    assign last_idx = IDX_W'(MIN_W - 1) + IDX_W'(cfg_q.wlen);

    // Next-state and control decode
    always_comb begin
        state_d     = state_q;
        idx_d       = idx_q;
        pbit_d      = pbit_q;
        mark_d      = mark_q;
        cfg_load    = 1'b0;
        tmr_restart = 1'b0;
        tmr_target  = BIT_T;
        st_clear    = 1'b0;
        st_wr       = 1'b0;
        emit        = 1'b0;
        emit_fe     = 1'b0;
        emit_brk    = 1'b0;
        emit_pe     = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (os_tick && !rx_line) begin
                    state_d     = ST_START;
                    tmr_restart = 1'b1;
                    st_clear    = 1'b1;
                    cfg_load    = 1'b1;
                    pbit_d      = 1'b0;
                end
            end
            ST_START: begin
                tmr_target = START_T;
                if (tmr_hit) begin
                    tmr_restart = 1'b1;
                    if (!rx_line) begin
                        state_d = ST_DATA;
                        idx_d   = '0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (tmr_hit) begin
                    st_wr = 1'b1;
                    if (idx_q == last_idx) begin
                        state_d = cfg_q.par_en ? ST_PARITY : ST_STOP;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                if (tmr_hit) begin
                    pbit_d  = rx_line;
                    state_d = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tmr_hit) begin
                    if (rx_line) begin
                        emit    = 1'b1;
                        emit_pe = 1'b1;
                        state_d = ST_IDLE;
                    end else if ((word_q == '0) && !pbit_q) begin
                        state_d     = ST_BRKCHK;
                        tmr_restart = 1'b1;
                    end else begin
                        emit        = 1'b1;
                        emit_pe     = 1'b1;
                        emit_fe     = 1'b1;
                        state_d     = ST_START;
                        tmr_restart = 1'b1;
                        st_clear    = 1'b1;
                        cfg_load    = 1'b1;
                        pbit_d      = 1'b0;
                    end
                end
            end
            ST_BRKCHK: begin
                tmr_target = BRK_T;
                if (tmr_hit) begin
                    emit    = 1'b1;
                    emit_fe = 1'b1;
                    if (!rx_line) begin
                        emit_brk = 1'b1;
                        mark_d   = 1'b0;
                        state_d  = ST_MARK;
                    end else begin
                        emit_pe = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_MARK: begin
                if (os_tick) begin
                    if (rx_line) begin
                        if (mark_q) state_d = ST_IDLE;
                        mark_d = 1'b1;
                    end else begin
                        mark_d = 1'b0;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pbit_q  <= 1'b0;
            mark_q  <= 1'b0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pbit_q  <= pbit_d;
            mark_q  <= mark_d;
            if (cfg_load) begin
                cfg_q <= '{wlen: cfg_wlen, par_en: cfg_par_en, par_odd: cfg_par_odd};
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_valid <= 1'b0;
            char_data  <= '0;
            char_perr  <= 1'b0;
            char_ferr  <= 1'b0;
            char_brk   <= 1'b0;
        end else begin
            char_valid <= emit;
            if (emit) begin
                char_data <= emit_brk ? '0 : word_q;
                char_perr <= emit_pe && perr_w;
                char_ferr <= emit_fe;
                char_brk  <= emit_brk;
            end
        end
    end

    // R9: the strobe lasts a single cycle
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // R9: every strobe follows a sample pulse
    a_r9_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> $past(os_tick));

    // R9: the state machine only moves on a sample pulse
    a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !os_tick |=> $stable(state_q));

    // R6: a break character carries zero data and a framing error, no parity error
    a_r6_brk_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && char_brk) |-> (char_ferr && !char_perr && (char_data == '0)));

    // R3: bits above the configured length read zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> ((char_data >> (MIN_W + int'(cfg_wlen))) == '0));

    // R4: no parity error when parity is disabled
    a_r4_noparity: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !cfg_par_en) |-> !char_perr);

    // R7: a low sample keeps the receiver in recovery
    a_r7_mark_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_MARK) && !rx_line) |=> (state_q == ST_MARK));

endmodule

// File: tb/srx_receiver_tb_top.sv
module srx_receiver_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       char_valid;
    logic [7:0] char_data;
    logic       char_perr, char_ferr, char_brk;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc = 0;
    int tick_cyc = -1;

    logic [10:0] exp_q [0:63];
    logic [10:0] got_q [0:63];
    int exp_n = 0;
    int got_n = 0;

    always #10 clk = ~clk;

    srx_receiver dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_line     (rx_line),
        .os_tick     (os_tick),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .char_valid  (char_valid),
        .char_data   (char_data),
        .char_perr   (char_perr),
        .char_ferr   (char_ferr),
        .char_brk    (char_brk)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (os_tick) tick_cyc = cyc;
        if (cyc > 190000) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog: actual %0d cycles, expected fewer than 190000", cyc);
            summary();
            $finish;
        end
    end

    // Capture characters; R9 timing of each strobe
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (char_valid) begin
                n_checks++;
                if (tick_cyc != cyc || prev_valid) begin
                    n_fails++;
                    $display("FAIL R9 strobe timing: actual tick cycle %0d prev %0b, expected %0d prev 0",
                             tick_cyc, prev_valid, cyc);
                end
                if (got_n < 64) got_q[got_n] = {char_brk, char_ferr, char_perr, char_data};
                got_n++;
            end
            prev_valid = char_valid;
        end
    end

    function automatic logic [7:0] wmask(input logic [1:0] wl);
        return 8'hFF >> (3 - wl);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] wl, input logic odd);
        return (^(d & wmask(wl))) ^ odd;
    endfunction

    task automatic tk(input logic v);
        rx_line = v;
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(input logic v, input int n);
        for (int i = 0; i < n; i++) tk(v);
    endtask

    task automatic push(input logic brk, input logic fe, input logic pe, input logic [7:0] d);
        if (exp_n < 64) exp_q[exp_n] = {brk, fe, pe, d};
        exp_n++;
    endtask

    task automatic body(input logic [7:0] d, input logic [1:0] wl, input logic pen,
                        input logic podd, input logic flip);
        cfg_wlen = wl; cfg_par_en = pen; cfg_par_odd = podd;
        run(1'b0, 16);
        for (int i = 0; i < 5 + int'(wl); i++) run(d[i], 16);
        if (pen) run(par_bit(d, wl, podd) ^ flip, 16);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [1:0] wl, input logic pen,
                              input logic podd, input logic flip, input logic bad);
        body(d, wl, pen, podd, flip);
        if (bad) begin
            run(1'b1, 7); run(1'b0, 1); run(1'b1, 8);
        end else begin
            run(1'b1, 16);
        end
        push(1'b0, bad, pen & flip, d & wmask(wl));
        run(1'b1, 2);
    endtask

    task automatic check_all(input string req);
        n_checks++;
        if (got_n != exp_n) begin
            n_fails++;
            $display("FAIL %s character count: actual %0d expected %0d", req, got_n, exp_n);
        end
        for (int i = 0; i < exp_n && i < got_n && i < 64; i++) begin
            n_checks++;
            if (got_q[i] !== exp_q[i]) begin
                n_fails++;
                $display("FAIL %s char %0d {brk,fe,pe,data}: actual %h expected %h",
                         req, i, got_q[i], exp_q[i]);
            end
        end
        got_n = 0;
        exp_n = 0;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4177);
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if ({char_valid, char_data, char_perr, char_ferr, char_brk} !== 12'h000) begin
            n_fails++;
            $display("FAIL R1 reset outputs: actual %h expected 000",
                     {char_valid, char_data, char_perr, char_ferr, char_brk});
        end
        rst_n = 1'b1;
        @(negedge clk);
        run(1'b1, 4);

        // R2: glitches of 3 and 7 low samples are rejected
        cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        run(1'b0, 3); run(1'b1, 20);
        run(1'b0, 7); run(1'b1, 40);
        check_all("R2");
        // R2: eight low samples confirm a start; all-high data gives 0xFF
        run(1'b0, 8); run(1'b1, 16 * 9 + 20);
        push(1'b0, 1'b0, 1'b0, 8'hFF);
        check_all("R2");

        // R3: each word length, LSB first
        send_frame(8'hB2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'hB2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'hB2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'hB2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all("R3");

        // R4: even and odd parity, right and wrong
        send_frame(8'h5B, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        send_frame(8'h5B, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
        send_frame(8'h17, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
        send_frame(8'h17, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
        check_all("R4");

        // R5: stop bit low only at its sample point
        send_frame(8'h5A, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1);
        check_all("R5");

        // R10: all-low frame one sample short of the break threshold
        cfg_wlen = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        run(1'b0, 16 * 11 - 1); run(1'b1, 20);
        push(1'b0, 1'b1, 1'b0, 8'h00);
        check_all("R10");

        // R6: long break gives one zero character
        run(1'b0, 16 * 11 + 30);
        push(1'b1, 1'b1, 1'b0, 8'h00);
        check_all("R6");
        // R7: one high then low is ignored; two highs re-arm
        run(1'b1, 1); run(1'b0, 16); run(1'b1, 2);
        check_all("R7");
        send_frame(8'h3C, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        check_all("R7");

        // R8: resynchronisation after a framing error
        body(8'h35, 2'd3, 1'b0, 1'b0, 1'b0);
        run(1'b0, 7);
        push(1'b0, 1'b1, 1'b0, 8'h35);
        send_frame(8'hA6, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all("R8");

        // Random frames covering R3, R4 and R5
        for (int k = 0; k < 50; k++) begin
            logic [7:0] d;
            logic [1:0] wl;
            logic pen, podd, flip, bad;
            d    = 8'($urandom);
            wl   = 2'($urandom % 4);
            pen  = 1'($urandom % 2);
            podd = 1'($urandom % 2);
            flip = ($urandom % 6) == 0;
            bad  = ($urandom % 6) == 0;
            send_frame(d, wl, pen, podd, flip, bad);
            check_all("R3/R4/R5 random");
        end

        summary();
        $finish;
    end

endmodule